// File: doc/BRIEF.md
# Program Counter Sequencer

This block keeps the 32-bit instruction fetch address of a small load/store RISC core. It computes the address for the next cycle from three inputs: the instruction word fetched at the current address, and the two register operand values read for that instruction. It handles one instruction per cycle. It recognises the control-transfer instructions itself and picks the matching target: plain word-by-word advance, a conditional branch relative to the following instruction, an absolute jump inside the current 256 MiB region, or a jump through a register.

For call instructions the block also tells the register file what to write back: an enable, the destination index and the return address (current address plus 4). The register file itself, instruction memory, exceptions and pipelining sit outside the block. The instruction on `instr_word` must be the one stored at `fetch_addr`. The operands must be the values of the registers that the instruction names in bits 25:21 (first operand) and 20:16 (second operand).

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the fetch address loads `START_ADDR` with its low two bits cleared. `link_we` is low during reset.
- R2: Any instruction that is not a control transfer advances the address by 4 at the next edge, modulo 2^32. This covers every opcode other than 0x02–0x05, and opcode 0x00 (bits 31:26) with a function code (bits 5:0) other than 0x08 and 0x09.
- R3: Opcode 0x04 compares the operands. If they are equal, the next address is current + 4 + 4 × sign-extended bits 15:0. Otherwise it is current + 4.
- R4: Opcode 0x05 takes the same relative target when the operands differ, and otherwise advances by 4.
- R5: Opcode 0x02 sets the next address to {current[31:28], bits 25:0, 2'b00}.
- R6: Opcode 0x03 jumps as in R5. In the same cycle it raises `link_we` with `link_idx` = 31 and `link_data` = current + 4.
- R7: Opcode 0x00 with function 0x08 sets the next address to the first operand with its low two bits forced to zero. No link write occurs.
- R8: Opcode 0x00 with function 0x09 jumps as in R7. In the same cycle it raises `link_we` with `link_idx` = bits 15:11 and `link_data` = current + 4.
- R9: The low two bits of `fetch_addr` are always zero.
- R10: `link_we` is high only in a cycle whose instruction is the one in R6 or R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Instruction fetched at `fetch_addr` |
| opnd_a | input | 32 | Value of the register named in bits 25:21 |
| opnd_b | input | 32 | Value of the register named in bits 20:16 |
| fetch_addr | output | 32 | Current instruction address |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register of the return address |
| link_data | output | 32 | Return address, current + 4 |

## Verification
A register-indirect call redirects the address and writes the return address in the same cycle. The target comes from the first operand, while the link value comes from the old address. The bench provokes this with calls whose operand is misaligned, whose destination index varies (including 0 and 31), and whose target lands next to the wrap point. In the cycle of the call it judges the link outputs against the address it tracks itself. After the edge it judges the new address against the operand with its low bits cleared.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int XLEN      = 32;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 6;
  localparam int RIDX_W    = 5;
  localparam int IMM_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int REGION_W  = 4;
  localparam int STEP      = 4;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_CALL  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNE  = 6'h05;
  localparam logic [FN_W-1:0]  FN_JREG   = 6'h08;
  localparam logic [FN_W-1:0]  FN_CREG   = 6'h09;
  localparam logic [RIDX_W-1:0] RET_REG  = 5'd31;

  typedef enum logic [1:0] {
    XF_SEQ    = 2'd0,
    XF_REL    = 2'd1,
    XF_ABS    = 2'd2,
    XF_REGJMP = 2'd3
  } xfer_e;

  typedef struct packed {
    xfer_e             kind;
    logic              on_differ;
    logic              link;
    logic [RIDX_W-1:0] link_idx;
  } ctl_t;

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] rel_addr(input logic [XLEN-1:0] pc,
                                               input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] wide;
    wide = {{(XLEN-IMM_W){off[IMM_W-1]}}, off};
    return seq_addr(pc) + (wide << 2);
  endfunction

  function automatic logic [XLEN-1:0] abs_addr(input logic [XLEN-1:0] pc,
                                               input logic [JIDX_W-1:0] idx);
    return {pc[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] reg_addr(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [FN_W-1:0]   fn,
  input  logic [RIDX_W-1:0] rd,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '{kind: XF_SEQ, on_differ: 1'b0, link: 1'b0, link_idx: '0};
    unique case (opc)
      OPC_BREQ: ctl.kind = XF_REL;
      OPC_BRNE: begin
        ctl.kind      = XF_REL;
        ctl.on_differ = 1'b1;
      end
      OPC_JMP:  ctl.kind = XF_ABS;
      OPC_CALL: begin
        ctl.kind     = XF_ABS;
        ctl.link     = 1'b1;
        ctl.link_idx = RET_REG;
      end
      OPC_REG: begin
        if (fn == FN_JREG) begin
          ctl.kind = XF_REGJMP;
        end else if (fn == FN_CREG) begin
          ctl.kind     = XF_REGJMP;
          ctl.link     = 1'b1;
          ctl.link_idx = rd;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
(
  input  logic [XLEN-1:0]   pc,
  input  ctl_t              ctl,
  input  logic [JIDX_W-1:0] field,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic [XLEN-1:0]   next_pc,
  output logic              redirect,
  output logic              branch_hit
);
  logic same;
  assign same       = (opnd_a == opnd_b);
  assign branch_hit = (ctl.kind == XF_REL) && (ctl.on_differ ? !same : same);

  always_comb begin
    unique case (ctl.kind)
      XF_REL:    next_pc = branch_hit ? rel_addr(pc, field[IMM_W-1:0]) : seq_addr(pc);
      XF_ABS:    next_pc = abs_addr(pc, field);
      XF_REGJMP: next_pc = reg_addr(opnd_a);
      default:   next_pc = seq_addr(pc);
    endcase
  end

  assign redirect = branch_hit || (ctl.kind == XF_ABS) || (ctl.kind == XF_REGJMP);
endmodule

// File: rtl/pcseq_pcreg.sv
module pcseq_pcreg
  import pcseq_pkg::*;
#(
  parameter logic [XLEN-1:0] START_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] START_AL = {START_ADDR[XLEN-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) pc <= START_AL;
    else     pc <= {next_pc[XLEN-1:2], 2'b00};
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter logic [31:0] START_ADDR = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr_word,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic [31:0] fetch_addr,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_data
);
  ctl_t             ctl_w;
  logic [XLEN-1:0]  next_w;
  logic             xfer_redirect;
  logic             xfer_branch_hit;

  pcseq_decode u_dec (
    .opc (instr_word[31:26]),
    .fn  (instr_word[5:0]),
    .rd  (instr_word[15:11]),
    .ctl (ctl_w)
  );

  pcseq_target u_tgt (
    .pc         (fetch_addr),
    .ctl        (ctl_w),
    .field      (instr_word[JIDX_W-1:0]),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .next_pc    (next_w),
    .redirect   (xfer_redirect),
    .branch_hit (xfer_branch_hit)
  );

  pcseq_pcreg #(.START_ADDR(START_ADDR)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .next_pc (next_w),
    .pc      (fetch_addr)
  );

  assign link_we   = !rst && ctl_w.link;
  assign link_idx  = ctl_w.link ? ctl_w.link_idx : '0;
  assign link_data = seq_addr(fetch_addr);
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter logic [31:0] START_ADDR = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  opc,
  input logic [5:0]  fn,
  input logic [31:2] a_hi,
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic [31:0] fetch_addr,
  input logic        link_we,
  input logic [31:0] link_data,
  input logic        redirect
);
  localparam logic [31:0] START_AL = {START_ADDR[31:2], 2'b00};

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fetch_addr == START_AL); // R1
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00); // R9
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> fetch_addr == $past(fetch_addr) + 32'd4); // R2
  AST_BREQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h04 && opnd_a != opnd_b) |=> fetch_addr == $past(fetch_addr) + 32'd4); // R3
  AST_BRNE_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h05 && opnd_a == opnd_b) |=> fetch_addr == $past(fetch_addr) + 32'd4); // R4
  AST_REGJMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h00 && (fn == 6'h08 || fn == 6'h09)) |=> fetch_addr == {$past(a_hi), 2'b00}); // R7
  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (opc == 6'h03 || (opc == 6'h00 && fn == 6'h09))); // R10
  AST_LINK_RETADDR: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_data == fetch_addr + 32'd4); // R6
endmodule

bind pc_sequencer pcseq_checker #(.START_ADDR(START_ADDR)) u_pcseq_chk (
  .clk        (clk),
  .rst        (rst),
  .opc        (instr_word[31:26]),
  .fn         (instr_word[5:0]),
  .a_hi       (opnd_a[31:2]),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .fetch_addr (fetch_addr),
  .link_we    (link_we),
  .link_data  (link_data),
  .redirect   (xfer_redirect)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam int          CLK_P = 10;
  localparam logic [31:0] START = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr_word, opnd_a, opnd_b;
  logic [31:0] fetch_addr, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [31:0] cur;
  bit          finished = 1'b0;

  pc_sequencer #(.START_ADDR(START)) u_pc_sequencer (
    .clk(clk), .rst(rst), .instr_word(instr_word), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .fetch_addr(fetch_addr), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic [31:0] a, input logic [31:0] b);
    int unsigned op = ins[31:26];
    int unsigned fn = ins[5:0];
    int          off = int'($signed(ins[15:0]));
    logic [31:0] after = pc + 32'd4;
    if ((op == 4 && a == b) || (op == 5 && a != b)) return after + 32'(off * 4);
    if (op == 2 || op == 3) return (pc & 32'hF000_0000) + 32'(ins[25:0]) * 32'd4;
    if (op == 0 && (fn == 8 || fn == 9)) return a - (a % 32'd4);
    return after;
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    int unsigned op = ins[31:26];
    int unsigned fn = ins[5:0];
    if (op == 4) return "R3";
    if (op == 5) return "R4";
    if (op == 2) return "R5";
    if (op == 3) return "R6";
    if (op == 0 && fn == 8) return "R7";
    if (op == 0 && fn == 9) return "R8";
    return "R2";
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expv = model_next(cur, ins, a, b);
    bit is_call = (ins[31:26] == 6'd3) || (ins[31:26] == 6'd0 && ins[5:0] == 6'd9);
    logic [4:0] exp_idx = (ins[31:26] == 6'd3) ? 5'd31 : ins[15:11];
    string t = tag_of(ins);
    @(negedge clk);
    instr_word = ins; opnd_a = a; opnd_b = b;
    #1;
    check("R10", {31'd0, link_we}, {31'd0, is_call});
    if (is_call) begin
      check(t, {27'd0, link_idx}, {27'd0, exp_idx});
      check(t, link_data, cur + 32'd4);
    end
    @(posedge clk); #1;
    check(t, fetch_addr, expv);
    check("R9", {30'd0, fetch_addr[1:0]}, 32'd0);
    cur = expv;
  endtask

  localparam logic [31:0] NOP = 32'h0000_0020;

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    instr_word = {6'd3, 26'h155_5555};  // call held during reset
    opnd_a = 0; opnd_b = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R1", fetch_addr, START);
    check("R1", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0; instr_word = NOP;
    @(posedge clk); #1;
    check("R2", fetch_addr, START + 32'd4);
    cur = START + 32'd4;

    // opcode sweep, with function sweep under opcode 0
    for (int op = 0; op < 64; op++) begin
      if (op == 0) begin
        for (int fn = 0; fn < 64; fn++) begin
          logic [31:0] a = 32'h0040_0000 + 32'(fn) * 32'h104 + 32'(fn % 4);
          step({6'd0, 5'd1, 5'd2, 5'(fn), 5'd0, 6'(fn)}, a, a ^ 32'(fn & 1));
        end
      end else begin
        logic [31:0] a = 32'h0020_0000 + 32'(op) * 32'h51;
        step({6'(op), 26'(32'h0ABC_D00 + op * 32'h333)}, a, (op % 2 == 1) ? a : a + 1);
      end
    end

    // relative branch sweep, both polarities, both outcomes
    for (int k = 0; k < 160; k++) begin
      logic [15:0] imm;
      logic [31:0] a = 32'(k) * 32'd3;
      case (k % 8)
        0: imm = 16'h7FFF;
        1: imm = 16'h8000;
        2: imm = 16'hFFFF;
        3: imm = 16'h0000;
        default: imm = 16'(k * 16'h2A9) ^ ((k % 2 == 1) ? 16'h8000 : 16'h0);
      endcase
      step({(k % 2 == 0) ? 6'd4 : 6'd5, 5'd4, 5'd5, imm}, a, (k % 3 == 0) ? a : a + 32'd1);
    end

    // wrap and region corners
    step({6'd0, 5'd1, 5'd0, 5'd0, 5'd0, 6'd8}, 32'hFFFF_FFFF, 0);  // R7 misaligned to top
    step(NOP, 0, 0);                                              // R2 wrap to zero
    step({6'd0, 5'd1, 5'd0, 5'd31, 5'd0, 6'd9}, 32'hF123_4566, 0); // R8 with rd 31
    step({6'd2, 26'h3FF_FFFF}, 0, 0);                             // R5 region top
    step({6'd0, 5'd1, 5'd0, 5'd0, 5'd0, 6'd9}, 32'h8000_0001, 0);  // R8 with rd 0
    step({6'd3, 26'h000_0001}, 0, 0);                             // R6 in upper region
    step({6'd4, 5'd0, 5'd0, 16'hFFFF}, 7, 7);                     // R3 branch to self
    step({6'd5, 5'd0, 5'd0, 16'h0001}, 7, 7);                     // R4 not taken

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule